// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel bytes. The raw line is brought into the clock domain through a short flop chain. It is then sampled eight times per bit cell, using a sample tick derived from the clock frequency and the baud rate. Each group of eight samples is reduced to a single bit by majority vote. A frame state machine then walks the start bit, the data bits (least significant first), an optional even parity bit and one or more stop bits. A frame that breaks any rule is discarded without a trace. A good frame updates the byte output and raises a one-cycle strobe.

The eight-sample window is not free-running. Whenever the synchronised line falls while no frame is in progress, the window and the sample tick restart, so each window lines up with a bit cell. Once a frame is under way, falling edges are ignored, so a glitch inside a cell cannot shift the windows. The byte output has no back-pressure: serial data cannot be held off. A consumer either takes the byte in the strobe cycle or reads it later from the output, which holds the last good byte until the next good one replaces it.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, rx_busy and rx_valid are 0 and rx_data is all zeros.
- R2: A bit is decided from eight samples taken one tick apart. It is 1 when at least four of the eight samples are high (a 4-4 tie resolves to 1) and 0 otherwise.
- R3: A falling edge on the synchronised line while rx_busy is 0 restarts the sample tick and the vote window and starts a frame, so a frame is received correctly whatever the idle time before it.
- R4: A falling edge while rx_busy is 1 does not restart the window. A short low blip inside a high bit cell of a frame leaves the received byte unchanged.
- R5: rx_busy goes to 1 the cycle after a falling edge starts a frame and stays 1 until the stop bits are decided or the frame is dropped. At any other time it is 0.
- R6: A start bit that votes high is a false start. The receiver returns to idle with no strobe.
- R7: The first data bit after the start bit is bit 0 of rx_data. DATA_BITS data bits are taken (8 by default).
- R8: When PARITY_EN is 1, one parity bit follows the last data bit. The XOR of the data bits and the parity bit must be 0 (even parity). Otherwise the frame is dropped with no strobe and rx_data unchanged.
- R9: STOP_BITS stop bits follow. Every one must vote high, or the frame is dropped with no strobe and rx_data unchanged.
- R10: rx_valid is high for exactly one cycle per good frame. rx_data changes only together with rx_valid and otherwise holds the last good byte.
- R11: Frames sent back to back, with no idle time between the last stop bit and the next start bit, are each received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_pin | input | 1 | Raw serial line, idle high |
| rx_data | output | DATA_BITS | Last correctly received byte |
| rx_valid | output | 1 | One-cycle strobe when rx_data takes a new byte |
| rx_busy | output | 1 | High while a frame is being received |

## Verification
The bench builds the receiver with eight data bits, parity enabled and two stop bits. This brings the parity check and the second stop bit into reach, including a failure in either stop position. The clock and baud parameters give a tick divider of 10, so a bit cell is 80 cycles. Each vote sample therefore falls at a known offset within the cell, and the bench can place low pulses over an exact number of samples: four for a tie, five for a majority, one inside a data cell to show that a busy receiver does not realign.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  // Clock cycles per sample tick, never below one.
  function automatic int unsigned tick_ratio(input int unsigned clk_hz,
                                             input int unsigned baud,
                                             input int unsigned os);
    int unsigned r;
    r = clk_hz / (baud * os);
    return (r < 1) ? 1 : r;
  endfunction

endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_raw,
  output logic line_s,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= line_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain[STAGES-1];
  end

  assign line_s = chain[STAGES-1];
  assign fall   = prev_q & ~chain[STAGES-1];
endmodule

// File: rtl/uart_os_rx_tick.sv
module uart_os_rx_tick #(
  parameter int unsigned DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW   = $clog2(DIV + 1);
  localparam int unsigned HALF = (DIV > 1) ? DIV / 2 : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= CW'(DIV - 1);
    else if (restart)  cnt <= CW'(HALF - 1);   // first sample near mid-tick
    else if (tick)     cnt <= CW'(DIV - 1);
    else               cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/uart_os_rx_vote.sv
module uart_os_rx_vote #(
  parameter int unsigned OS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  input  logic line_s,
  output logic bit_valid,
  output logic bit_val
);
  localparam int unsigned IW     = $clog2(OS);
  localparam int unsigned OW     = $clog2(OS + 1);
  localparam int unsigned THRESH = OS / 2;

  logic [IW-1:0] idx;
  logic [OW-1:0] ones;
  logic [OW-1:0] ones_nx;

  assign ones_nx = ones + OW'(line_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx       <= '0;
      ones      <= '0;
      bit_valid <= 1'b0;
      bit_val   <= 1'b1;
    end else begin
      bit_valid <= 1'b0;
      if (restart) begin
        idx  <= '0;
        ones <= '0;
      end else if (tick) begin
        if (idx == IW'(OS - 1)) begin
          idx       <= '0;
          ones      <= '0;
          bit_valid <= 1'b1;
          bit_val   <= (ones_nx >= OW'(THRESH));
        end else begin
          idx  <= idx + 1'b1;
          ones <= ones_nx;
        end
      end
    end
  end
endmodule

// File: rtl/uart_os_rx_frame.sv
module uart_os_rx_frame
  import uart_os_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter bit PARITY_EN = 1'b0,
  parameter int STOP_BITS = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fall,
  input  logic                 bit_valid,
  input  logic                 bit_val,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 rx_busy
);
  localparam int MAXC  = (DATA_BITS > STOP_BITS) ? DATA_BITS : STOP_BITS;
  localparam int CNT_W = $clog2(MAXC + 1);

  rx_state_e            state;
  logic [CNT_W-1:0]     cnt;
  logic [DATA_BITS-1:0] shreg;
  logic                 par_ok;
  rx_state_e            after_data;

  generate
    if (PARITY_EN) begin : g_par
      assign par_ok     = ~(^shreg ^ bit_val);
      assign after_data = ST_PAR;
    end else begin : g_nopar
      assign par_ok     = 1'b1;
      assign after_data = ST_STOP;
    end
  endgenerate

  assign rx_busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (fall) state <= ST_START;
        end
        ST_START: begin
          if (bit_valid) begin
            cnt   <= '0;
            state <= bit_val ? ST_IDLE : ST_DATA;
          end
        end
        ST_DATA: begin
          if (bit_valid) begin
            shreg <= {bit_val, shreg[DATA_BITS-1:1]};
            if (cnt == CNT_W'(DATA_BITS - 1)) begin
              cnt   <= '0;
              state <= after_data;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_PAR: begin
          if (bit_valid) state <= par_ok ? ST_STOP : ST_IDLE;
        end
        ST_STOP: begin
          if (bit_valid) begin
            if (!bit_val) begin
              state <= ST_IDLE;
            end else if (cnt == CNT_W'(STOP_BITS - 1)) begin
              state    <= ST_IDLE;
              rx_data  <= shreg;
              rx_valid <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_os_rx_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned BAUD        = 9600,
  parameter int          DATA_BITS   = 8,
  parameter bit          PARITY_EN   = 1'b0,
  parameter int          STOP_BITS   = 1,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_pin,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 rx_busy
);
  localparam int unsigned OS  = 8;
  localparam int unsigned DIV = tick_ratio(CLK_HZ, BAUD, OS);

  logic line_s, fall, restart, tick, bit_valid, bit_val;

  assign restart = fall & ~rx_busy;

  uart_os_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_raw(rx_pin), .line_s(line_s), .fall(fall)
  );

  uart_os_rx_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
  );

  uart_os_rx_vote #(.OS(OS)) u_vote (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick), .line_s(line_s),
    .bit_valid(bit_valid), .bit_val(bit_val)
  );

  uart_os_rx_frame #(
    .DATA_BITS(DATA_BITS), .PARITY_EN(PARITY_EN), .STOP_BITS(STOP_BITS)
  ) u_frame (
    .clk(clk), .rst_n(rst_n), .fall(fall), .bit_valid(bit_valid),
    .bit_val(bit_val), .rx_data(rx_data), .rx_valid(rx_valid), .rx_busy(rx_busy)
  );
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fall,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 rx_valid,
  input logic                 rx_busy
);
  // R10: strobe lasts one cycle
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R10: data moves only with the strobe
  a_r10_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data));

  // R5: a strobe closes a frame that was in progress
  a_r5_strobe_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (!rx_busy && $past(rx_busy)));

  // R5: a frame only opens after a line fall
  a_r5_busy_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_busy) |-> $past(fall));

  // R3: a fall while idle opens a frame
  a_r3_fall_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !rx_busy) |=> rx_busy);
endmodule

bind uart_os_rx uart_os_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .fall(fall), .rx_data(rx_data),
  .rx_valid(rx_valid), .rx_busy(rx_busy)
);

// File: tb/uart_os_rx_test.sv
`timescale 1ns/1ps
module uart_os_rx_test;
  localparam int BIT = 80;   // cycles per bit cell: divider 10 x 8 samples

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_busy;

  int checks = 0;
  int failures = 0;
  int strobes = 0;
  int wide = 0;
  logic prev_valid = 1'b0;
  logic [7:0] caught [0:63];
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_os_rx #(
    .CLK_HZ(125_000_000), .BAUD(1_562_500), .DATA_BITS(8),
    .PARITY_EN(1'b1), .STOP_BITS(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_line),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_busy(rx_busy)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        if (strobes < 64) caught[strobes] = rx_data;
        strobes = strobes + 1;
        if (prev_valid) wide = wide + 1;
      end
      prev_valid = rx_valid;
    end
  end

  // {data[7:0], fault[1:0] (0 none, 1 parity, 2 first stop, 3 second stop), good}
  localparam logic [10:0] VEC [0:9] = '{
    {8'h01, 2'd0, 1'b1}, {8'h80, 2'd0, 1'b1}, {8'hA5, 2'd1, 1'b0},
    {8'h3C, 2'd0, 1'b1}, {8'hFF, 2'd2, 1'b0}, {8'h00, 2'd3, 1'b0},
    {8'h5A, 2'd0, 1'b1}, {8'hC3, 2'd1, 1'b0}, {8'hFF, 2'd0, 1'b1},
    {8'h00, 2'd0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rx_line = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [1:0] fault);
    hold(1'b0, BIT);
    for (int b = 0; b < 8; b++) hold(d[b], BIT);
    hold((^d) ^ (fault == 2'd1), BIT);
    hold(fault != 2'd2, BIT);
    hold(fault != 2'd3, BIT);
    rx_line = 1'b1;
  endtask

  // Good frame with a short low pulse inside data bit 0 (which must be 1)
  task automatic send_blip(input logic [7:0] d);
    hold(1'b0, BIT);
    hold(1'b1, 30); hold(1'b0, 12); hold(1'b1, BIT - 42);
    for (int b = 1; b < 8; b++) hold(d[b], BIT);
    hold(^d, BIT);
    hold(1'b1, 2 * BIT);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures = failures + 1;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int s0;
    logic [7:0] last_good;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 busy", rx_busy, 0);
    chk("R1 valid", rx_valid, 0);
    chk("R1 data", rx_data, 0);
    rst_n = 1'b1;
    repeat (37) @(negedge clk);
    last_good = 8'h00;

    // Vector walk: R3 (varied idle phase), R7, R8, R9, R10
    for (int i = 0; i < 10; i++) begin
      s0 = strobes;
      repeat (23 + i * 17) @(negedge clk);
      send_frame(VEC[i][10:3], VEC[i][2:1]);
      repeat (16) @(negedge clk);
      if (VEC[i][0]) last_good = VEC[i][10:3];
      chk($sformatf("R3/R8/R9 strobe count vec %0d", i), strobes - s0, {31'd0, VEC[i][0]});
      chk($sformatf("R7/R10 data vec %0d", i), rx_data, last_good);
    end

    // R6 false start: two low samples
    s0 = strobes;
    hold(1'b0, 20); hold(1'b1, 8);
    chk("R5 busy after start edge", rx_busy, 1);
    repeat (100) @(negedge clk);
    chk("R6 false start idle", rx_busy, 0);
    chk("R6 false start no strobe", strobes - s0, 0);

    // R2 tie: four low samples of eight votes high
    hold(1'b0, 40); hold(1'b1, 60);
    chk("R2 tie votes high", rx_busy, 0);
    // R2 five low samples vote low: frame proceeds, then fails parity
    s0 = strobes;
    hold(1'b0, 50); hold(1'b1, 50);
    chk("R2 five low votes low", rx_busy, 1);
    repeat (12 * BIT) @(negedge clk);
    chk("R8 all-ones frame bad parity idle", rx_busy, 0);
    chk("R8 bad parity no strobe", strobes - s0, 0);

    // R5 busy through the frame
    fork
      send_frame(8'h96, 2'd0);
      begin
        repeat (6 * BIT) @(negedge clk);
        chk("R5 busy mid frame", rx_busy, 1);
      end
    join
    repeat (16) @(negedge clk);
    chk("R5 idle after frame", rx_busy, 0);

    // R4 blip inside a busy frame does not realign
    s0 = strobes;
    repeat (41) @(negedge clk);
    send_blip(8'hA5);
    chk("R4 blip frame strobe", strobes - s0, 1);
    chk("R4 blip frame data", rx_data, 8'hA5);

    // R11 back to back
    s0 = strobes;
    repeat (29) @(negedge clk);
    send_frame(8'h12, 2'd0);
    send_frame(8'h34, 2'd0);
    repeat (16) @(negedge clk);
    chk("R11 two strobes", strobes - s0, 2);
    chk("R11 first byte", caught[s0], 8'h12);
    chk("R11 second byte", caught[s0 + 1], 8'h34);

    chk("R10 strobe width", wide, 0);
    done = 1'b1;
    finish_run();
  end
endmodule